// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block keeps a small store of instruction bytes ready for a decoder. It owns a fetch pointer, asks a 16-bit memory port for the next aligned word whenever enough room is free, and writes the returned bytes into a circular byte store. The decoder takes bytes one at a time through a valid/ready handshake. Fetching and consuming overlap, so the memory port can be refilling the store while earlier bytes are being used.

A flush input gives a new target address. It empties the store, cancels a fetch that memory has not yet accepted, discards data that arrives in the flush cycle, and reloads the pointer. When the target is odd, the first word fetch keeps only its upper byte. Word-aligned fetches follow from then on. A parameter selects a narrow-bus variant with four byte slots that fetches one byte whenever a single slot is free.

The fetch controller has two states. In `S_IDLE` no request is out. It moves to `S_FETCH` (transition "launch") when the free slot count reaches the fetch threshold and no flush is present. In `S_FETCH` the request is held. It returns to `S_IDLE` on acknowledge (transition "land") or on flush (transition "cancel"). A flush in `S_IDLE` keeps the controller in `S_IDLE` (transition "retarget").

Top module: `prefetch_queue`

## Requirements
- R1: While reset is asserted, `dec_valid` and `mem_req` are low.
- R2: In the wide variant a word fetch from an even pointer enqueues two bytes. The low data lane (bits 7:0) holds the byte at the even address and is delivered first. The high lane (bits 15:8) holds the byte at the address plus one.
- R3: A request is raised only when the free slots are at least the threshold: 2 in the wide variant, 1 in the narrow one. With 5 of 6 wide slots full, no request is raised.
- R4: The store never holds more than its depth: 6 bytes in the wide variant, 4 in the narrow one.
- R5: The decoder receives bytes in strictly increasing address order. `dec_valid` is low while the store is empty.
- R6: In the wide variant `mem_addr` is always even. After a flush to an odd target, the first fetch enqueues only the high-lane byte, which is the byte at the target.
- R7: A flush empties the store, so `dec_valid` is low in the cycle after the flush edge. The next fetch is made from the new target.
- R8: Data acknowledged in the same cycle as a flush is not enqueued.
- R9: The fetch pointer advances by exactly the number of bytes enqueued, so each `mem_addr` follows on from the bytes already taken.
- R10: With `NARROW`=1 the store holds 4 bytes. Each fetch requests the byte at the pointer itself, odd or even, and takes it from the low lane.
- R11: Once raised, `mem_req` and `mem_addr` hold steady until acknowledge or flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty the store and jump to `flush_addr` |
| flush_addr | input | ADDR_W | New fetch target |
| mem_req | output | 1 | Fetch request, held until acknowledged |
| mem_addr | output | ADDR_W | Fetch address (word-aligned in wide variant) |
| mem_ack | input | 1 | Memory accepts the request; `mem_rdata` is valid this cycle |
| mem_rdata | input | 16 | Returned data, low lane at even address |
| dec_valid | output | 1 | A byte is available |
| dec_byte | output | 8 | Oldest byte in the store |
| dec_ready | input | 1 | Decoder takes the byte this cycle |

## Verification
An acknowledge at an edge makes its bytes visible on `dec_valid`/`dec_byte` right after that edge. A consumption at an edge can raise `mem_req` one edge later, because the controller first moves to `S_FETCH`. A flush edge drops `dec_valid` immediately after it, and the first request to the new target appears one edge after that. The bench drives every input on the falling edge and samples on the falling edge. Wherever the requirement fixes the cycle, it checks at the exact falling edge after the counted edges. Elsewhere it waits for `mem_req` or `dec_valid` with a bounded loop and checks the address or byte it finds.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_FETCH = 1'b1
    } pfq_state_t;
endpackage

// File: rtl/pfq_store.sv
module pfq_store #(
    parameter int DEPTH = 6,
    parameter int CNT_W = 3,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [1:0]       push_n,
    input  logic [7:0]       push_b0,
    input  logic [7:0]       push_b1,
    input  logic             pop,
    output logic [7:0]       head,
    output logic [CNT_W-1:0] occ
);
    localparam int SUM_W = IDX_W + 1;

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i, input logic [1:0] n);
        logic [SUM_W-1:0] s;
        s = {1'b0, i} + SUM_W'(n);
        if (s >= SUM_W'(DEPTH)) s = s - SUM_W'(DEPTH);
        return s[IDX_W-1:0];
    endfunction

    logic [7:0]       slot [DEPTH];
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] wr_idx_p1;

    assign wr_idx_p1 = step(wr_idx, 2'd1);

    // one write port pair per slot
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push_n != 2'd0 && wr_idx == IDX_W'(g)) begin
                slot[g] <= push_b0;
            end else if (push_n == 2'd2 && wr_idx_p1 == IDX_W'(g)) begin
                slot[g] <= push_b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_idx <= '0;
            wr_idx <= '0;
            occ    <= '0;
        end else begin
            wr_idx <= step(wr_idx, push_n);
            if (pop) rd_idx <= step(rd_idx, 2'd1);
            occ <= occ + CNT_W'(push_n) - CNT_W'(pop);
        end
    end

    assign head = slot[rd_idx];
endmodule

// File: rtl/pfq_fetch_ctrl.sv
module pfq_fetch_ctrl
    import pfq_pkg::*;
#(
    parameter int              ADDR_W     = 20,
    parameter int              LANES      = 2,
    parameter int              THRESH     = 2,
    parameter int              CNT_W      = 3,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic [CNT_W-1:0]  free_slots,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        push_n,
    output logic [7:0]        push_b0,
    output logic [7:0]        push_b1
);
    pfq_state_t        state_q, state_d;
    logic [ADDR_W-1:0] ptr_q;
    logic [1:0]        lane_n;
    logic [7:0]        lane_b0, lane_b1;
    logic [ADDR_W-1:0] lane_addr;
    logic              take;

    // lane steering picked by bus width
    if (LANES == 1) begin : g_narrow
        assign lane_addr = ptr_q;
        assign lane_n    = 2'd1;
        assign lane_b0   = mem_rdata[7:0];
        assign lane_b1   = mem_rdata[15:8];
    end else begin : g_wide
        assign lane_addr = {ptr_q[ADDR_W-1:1], 1'b0};
        assign lane_n    = ptr_q[0] ? 2'd1 : 2'd2;
        assign lane_b0   = ptr_q[0] ? mem_rdata[15:8] : mem_rdata[7:0];
        assign lane_b1   = mem_rdata[15:8];
    end

    // state and pointer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            ptr_q   <= RESET_ADDR;
        end else begin
            state_q <= state_d;
            if (flush)     ptr_q <= flush_addr;
            else if (take) ptr_q <= ptr_q + ADDR_W'(lane_n);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (!flush && free_slots >= CNT_W'(THRESH)) state_d = S_FETCH;
            end
            S_FETCH: begin
                if (flush || mem_ack) state_d = S_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        mem_req  = 1'b0;
        mem_addr = lane_addr;
        take     = 1'b0;
        unique case (state_q)
            S_IDLE:  mem_req = 1'b0;
            S_FETCH: begin
                mem_req = 1'b1;
                take    = mem_ack && !flush;
            end
        endcase
        push_n  = take ? lane_n : 2'd0;
        push_b0 = lane_b0;
        push_b1 = lane_b1;
    end
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
    parameter int                ADDR_W     = 20,
    parameter bit                NARROW     = 1'b0,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [15:0]       mem_rdata,
    output logic              dec_valid,
    output logic [7:0]        dec_byte,
    input  logic              dec_ready
);
    localparam int DEPTH  = NARROW ? 4 : 6;
    localparam int LANES  = NARROW ? 1 : 2;
    localparam int THRESH = LANES;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int IDX_W  = $clog2(DEPTH);

    logic [CNT_W-1:0] occ;
    logic [CNT_W-1:0] free_slots;
    logic [1:0]       push_n;
    logic [7:0]       push_b0, push_b1;
    logic             pop;

    assign free_slots = CNT_W'(DEPTH) - occ;
    assign dec_valid  = (occ != '0);
    assign pop        = dec_valid && dec_ready && !flush;

    pfq_fetch_ctrl #(
        .ADDR_W(ADDR_W), .LANES(LANES), .THRESH(THRESH),
        .CNT_W(CNT_W), .RESET_ADDR(RESET_ADDR)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .free_slots(free_slots), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1)
    );

    pfq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(flush),
        .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1),
        .pop(pop), .head(dec_byte), .occ(occ)
    );
endmodule

// File: rtl/prefetch_queue_checker.sv
module prefetch_queue_checker #(
    parameter int ADDR_W = 20,
    parameter bit NARROW = 1'b0,
    parameter int DEPTH  = 6,
    parameter int THRESH = 2,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              flush,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              dec_valid,
    input logic [CNT_W-1:0]  occ
);
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    a_r3_room_on_launch: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req) |-> (CNT_W'(DEPTH) - occ) >= CNT_W'(THRESH));

    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !flush) |=> (mem_req && $stable(mem_addr)));

    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !dec_valid);

    a_r8_stale_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && mem_req && mem_ack) |=> (occ == '0));

    a_r6_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (NARROW || !mem_addr[0]));
endmodule

bind prefetch_queue prefetch_queue_checker #(
    .ADDR_W(ADDR_W), .NARROW(NARROW), .DEPTH(DEPTH), .THRESH(THRESH), .CNT_W(CNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .flush(flush), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .dec_valid(dec_valid), .occ(occ)
);

// File: tb/tb_prefetch_queue.sv
module tb_prefetch_queue;
    localparam int AW = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;

    // wide instance
    logic          flush = 1'b0;
    logic [AW-1:0] flush_addr = '0;
    logic          mem_req, mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [15:0]   mem_rdata = '0;
    logic          dec_valid, dec_ready = 1'b0;
    logic [7:0]    dec_byte;

    // narrow instance
    logic          n_flush = 1'b0;
    logic [AW-1:0] n_flush_addr = '0;
    logic          n_req, n_ack = 1'b0;
    logic [AW-1:0] n_addr;
    logic [15:0]   n_rdata = '0;
    logic          n_valid, n_ready = 1'b0;
    logic [7:0]    n_byte;

    prefetch_queue #(.ADDR_W(AW), .NARROW(1'b0), .RESET_ADDR(20'h00100)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .dec_valid(dec_valid), .dec_byte(dec_byte), .dec_ready(dec_ready));

    prefetch_queue #(.ADDR_W(AW), .NARROW(1'b1), .RESET_ADDR(20'h00040)) dut_n (
        .clk(clk), .rst_n(rst_n), .flush(n_flush), .flush_addr(n_flush_addr),
        .mem_req(n_req), .mem_addr(n_addr), .mem_ack(n_ack), .mem_rdata(n_rdata),
        .dec_valid(n_valid), .dec_byte(n_byte), .dec_ready(n_ready));

    function automatic logic [7:0] mbyte(input logic [AW-1:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h3C;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // wide memory model: latency and hold knobs
    int lat = 0;
    bit hold = 1'b0;
    initial begin
        int waitc = 0;
        forever begin
            @(negedge clk);
            if (!hold) begin
                if (mem_req && !mem_ack && waitc >= lat) begin
                    mem_ack   = 1'b1;
                    mem_rdata = {mbyte(mem_addr | 20'h1), mbyte(mem_addr & ~20'h1)};
                    waitc     = 0;
                end else begin
                    mem_ack = 1'b0;
                    if (mem_req) waitc++;
                    else waitc = 0;
                end
            end
        end
    end

    // narrow memory model: zero latency, junk in upper lane
    initial begin
        forever begin
            @(negedge clk);
            if (n_req && !n_ack) begin
                n_ack   = 1'b1;
                n_rdata = {8'hFF, mbyte(n_addr)};
            end else begin
                n_ack = 1'b0;
            end
        end
    end

    task automatic pop_w(input logic [AW-1:0] a, input string tag);
        int k = 0;
        @(negedge clk);
        while (!dec_valid && k < 200) begin @(negedge clk); k++; end
        check(dec_valid && dec_byte == mbyte(a), tag, {24'h0, dec_byte}, {24'h0, mbyte(a)});
        dec_ready = 1'b1;
        @(negedge clk);
        dec_ready = 1'b0;
    endtask

    task automatic pop_n(input logic [AW-1:0] a, input string tag);
        int k = 0;
        @(negedge clk);
        while (!n_valid && k < 200) begin @(negedge clk); k++; end
        check(n_valid && n_byte == mbyte(a), tag, {24'h0, n_byte}, {24'h0, mbyte(a)});
        n_ready = 1'b1;
        @(negedge clk);
        n_ready = 1'b0;
    endtask

    task automatic wait_req_rise();
        int k = 0;
        while (mem_req && k < 200) begin @(negedge clk); k++; end
        while (!mem_req && k < 400) begin @(negedge clk); k++; end
    endtask

    task automatic do_flush(input logic [AW-1:0] a);
        @(negedge clk);
        flush = 1'b1;
        flush_addr = a;
        @(negedge clk);
        flush = 1'b0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!dec_valid, "R1 valid in reset", 32'(dec_valid), 0);
        check(!mem_req, "R1 req in reset", 32'(mem_req), 0);
    endtask

    task automatic t_fill_and_threshold();
        repeat (30) @(negedge clk);
        check(!mem_req, "R4 full queue stops fetching", 32'(mem_req), 0);
        check(dec_valid, "R5 valid when filled", 32'(dec_valid), 1);
        pop_w(20'h00100, "R2 low lane first");
        repeat (10) @(negedge clk);
        check(!mem_req, "R3 no fetch with one slot free", 32'(mem_req), 0);
        pop_w(20'h00101, "R2 high lane second");
        @(negedge clk);
        check(mem_req, "R3 fetch once two slots free", 32'(mem_req), 1);
        check(mem_addr == 20'h00106, "R9 pointer after six bytes", 32'(mem_addr), 32'h106);
        for (int i = 2; i < 12; i++) pop_w(20'h00100 + AW'(i), "R5 address order");
    endtask

    task automatic t_odd_flush();
        do_flush(20'h02001);
        check(!dec_valid, "R7 flush empties queue", 32'(dec_valid), 0);
        wait_req_rise();
        check(mem_addr == 20'h02000, "R6 odd target word address", 32'(mem_addr), 32'h2000);
        wait_req_rise();
        check(mem_addr == 20'h02002, "R9 pointer after one byte", 32'(mem_addr), 32'h2002);
        for (int i = 1; i < 9; i++) pop_w(20'h02000 + AW'(i), "R6 odd start order");
    endtask

    task automatic t_stale_data();
        hold = 1'b1;
        do_flush(20'h03000);
        wait_req_rise();
        check(mem_addr == 20'h03000, "R7 fetch from new target", 32'(mem_addr), 32'h3000);
        @(negedge clk);
        mem_ack = 1'b1;
        mem_rdata = 16'hEEEE;
        flush = 1'b1;
        flush_addr = 20'h04000;
        @(negedge clk);
        mem_ack = 1'b0;
        flush = 1'b0;
        hold = 1'b0;
        check(!dec_valid, "R8 stale data not enqueued", 32'(dec_valid), 0);
        for (int i = 0; i < 4; i++) pop_w(20'h04000 + AW'(i), "R8 first byte from new target");
    endtask

    task automatic t_slow_memory();
        lat = 3;
        do_flush(20'h05000);
        for (int i = 0; i < 10; i++) pop_w(20'h05000 + AW'(i), "R5 order with slow memory");
        lat = 0;
    endtask

    task automatic t_narrow();
        check(!n_req, "R10 narrow full at four", 32'(n_req), 0);
        pop_n(20'h00040, "R10 narrow first byte");
        @(negedge clk);
        check(n_req, "R10 narrow fetch with one slot", 32'(n_req), 1);
        check(n_addr == 20'h00044, "R10 narrow pointer", 32'(n_addr), 32'h44);
        for (int i = 1; i < 8; i++) pop_n(20'h00040 + AW'(i), "R10 narrow order");
        @(negedge clk);
        n_flush = 1'b1;
        n_flush_addr = 20'h00071;
        @(negedge clk);
        n_flush = 1'b0;
        @(negedge clk);
        check(n_req && n_addr == 20'h00071, "R10 narrow odd byte address", 32'(n_addr), 32'h71);
        for (int i = 0; i < 3; i++) pop_n(20'h00071 + AW'(i), "R10 narrow after flush");
    endtask

    initial begin
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_fill_and_threshold();
        t_odd_flush();
        t_stale_data();
        t_slow_memory();
        t_narrow();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule